// File: doc/BRIEF.md
# Scanline Interrupt Counter by Fetch Snooping

This block listens to a video processor's memory bus, watching only the fetch address and the active-low read strobe, and finds the end of each rendered line without any sync signal. Near the end of every line, the video processor makes two dummy reads in a row from the nametable window. Outside that point, normal rendering never puts two such reads back to back. Each time the block sees that pair, it advances a line counter and compares the new count with a target line that the CPU programs. On a match it pulls an active-low interrupt line low.

A second detector watches the CPU bus clock. When two whole CPU clock periods pass with no video read at all, the video device has stopped rendering. The block then clears the line counter, the in-frame flag and the pair detector, ready for the next frame. The CPU reads a two-bit status. The read returns the pending and in-frame bits and acknowledges the interrupt.

The strobe and the CPU clock are asynchronous to the block clock. Each passes through a parameterised flop synchroniser before its edges are detected, so all state has a single writer. The fetch address must stay stable for the whole low phase of the read strobe.

Top module: `scanline_irq_snoop`

## Requirements
- R1: In region mode (EXACT_MATCH=0), a fetch counts as a nametable read when address bit 13 is 1 and bit 12 is 0. A fetch at 0x3000 (bits 13 and 12 both 1) does not count.
- R2: In region mode, two nametable reads in a row produce one line tick. The tick clears the pair flag, so a third consecutive nametable read does not tick, and a fourth does. Any non-nametable read in between clears the flag.
- R3: Each line tick adds one to the line counter and sets the in-frame flag.
- R4: When the incremented count equals the target, the pending flag sets and irqN goes low. It stays low through later lines until the CPU acknowledges.
- R5: A status read (statusRd high for one clock) presents statusData with bit 1 = pending and bit 0 = in-frame. On the next clock it clears pending, and irqN returns high.
- R6: Writing the target register leaves the line counter unchanged.
- R7: The end of the frame is detected when two consecutive CPU-clock periods (rising edge to rising edge) contain no read-strobe falling edge. This clears the counter, the in-frame flag and the pair flag.
- R8: A single quiet CPU-clock period between busy ones changes nothing.
- R9: With EXACT_MATCH=1, a tick needs two consecutive fetches with identical 14-bit addresses, whatever their region. A tick consumes the pair, and different nametable addresses in a row do not tick.
- R10: After reset, irqN is high and statusData is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, faster than both snooped signals |
| rstN | input | 1 | Asynchronous active-low reset |
| videoRdN | input | 1 | Video bus read strobe, active low, asynchronous |
| fetchAddr | input | ADDR_W | Video fetch address, stable while videoRdN is low |
| cpuM2 | input | 1 | CPU bus clock, asynchronous |
| tgtWr | input | 1 | One-clock write strobe for the target line |
| tgtData | input | CNT_W | Target line value |
| statusRd | input | 1 | One-clock status read; acknowledges the interrupt |
| statusData | output | 2 | {pending, inFrame} |
| irqN | output | 1 | Active-low interrupt request |

## Verification
On every cycle, the embedded properties check several invariants. A tick lasts one clock. Each tick steps the counter by exactly one and sets the in-frame flag. An idle reset leaves the counter at zero and in-frame clear. A target match drives irqN low, and an acknowledge without a tick releases it. Only the bench scenarios can show the behaviours that depend on fetch order. These are the pair and third-read rule, the region decode against exact matching, the two-quiet-period idle threshold, and the target write that leaves the counter running. The bench sweeps targets across a frame of modelled lines for both compare modes.

// File: rtl/scanline_snoop_pkg.sv
package scanline_snoop_pkg;
  // Strobes handed from the control to the datapath, one clock wide each
  typedef struct packed {
    logic tick;       // end-of-line pair seen
    logic idleReset;  // video bus quiet for two CPU periods
    logic ack;        // status read acknowledges pending
  } snoopStrobes_t;
endpackage

// File: rtl/snoop_ctrl.sv
module snoop_ctrl
  import scanline_snoop_pkg::*;
#(
  parameter int ADDR_W      = 14,
  parameter int SYNC_STAGES = 2,
  parameter bit EXACT_MATCH = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              videoRdN,
  input  logic              cpuM2,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic              statusRd,
  output snoopStrobes_t     strobes
);
  localparam int NT_HI = ADDR_W - 1;
  localparam int NT_LO = ADDR_W - 2;
  localparam int LAST  = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] rdPipe, m2Pipe;
  logic rdDly, m2Dly;
  logic rdFall, m2Rise;
  logic readSeen, quietPrev;
  logic idleW, tickW;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPipe <= '1;
      m2Pipe <= '0;
      rdDly  <= 1'b1;
      m2Dly  <= 1'b0;
    end else begin
      rdPipe <= {rdPipe[LAST-1:0], videoRdN};
      m2Pipe <= {m2Pipe[LAST-1:0], cpuM2};
      rdDly  <= rdPipe[LAST];
      m2Dly  <= m2Pipe[LAST];
    end
  end

  assign rdFall = rdDly & ~rdPipe[LAST];
  assign m2Rise = ~m2Dly & m2Pipe[LAST];

  // Quiet-bus watch, evaluated on CPU clock rising edges
  assign idleW = m2Rise & ~readSeen & quietPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readSeen  <= 1'b0;
      quietPrev <= 1'b0;
    end else begin
      if (rdFall)      readSeen <= 1'b1;
      else if (m2Rise) readSeen <= 1'b0;
      if (m2Rise) quietPrev <= ~readSeen;
    end
  end

  generate
    if (EXACT_MATCH) begin : g_exact
      logic [ADDR_W-1:0] lastAddr;
      logic              lastValid;
      assign tickW = rdFall & lastValid & (fetchAddr == lastAddr);
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          lastAddr  <= '0;
          lastValid <= 1'b0;
        end else if (idleW) begin
          lastValid <= 1'b0;
        end else if (rdFall) begin
          lastAddr  <= fetchAddr;
          lastValid <= ~tickW;
        end
      end
    end else begin : g_region
      logic ntPrev;
      logic isNt;
      assign isNt  = fetchAddr[NT_HI] & ~fetchAddr[NT_LO];
      assign tickW = rdFall & isNt & ntPrev;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)       ntPrev <= 1'b0;
        else if (idleW)  ntPrev <= 1'b0;
        else if (rdFall) ntPrev <= isNt & ~ntPrev;
      end
    end
  endgenerate

  assign strobes.tick      = tickW;
  assign strobes.idleReset = idleW;
  assign strobes.ack       = statusRd;

  // R2: a strobe edge yields at most one tick
  p_tick_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    tickW |=> !tickW);
endmodule

// File: rtl/snoop_dp.sv
module snoop_dp
  import scanline_snoop_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  snoopStrobes_t    strobes,
  input  logic             tgtWr,
  input  logic [CNT_W-1:0] tgtData,
  output logic             pending,
  output logic             inFrame,
  output logic             irqN
);
  logic [CNT_W-1:0] lineCount, target, nextCount;
  logic tickEff, hit;

  assign tickEff   = strobes.tick & ~strobes.idleReset;
  assign nextCount = lineCount + 1'b1;
  assign hit       = tickEff & (nextCount == target);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) target <= '0;
    else if (tgtWr) target <= tgtData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineCount <= '0;
      inFrame   <= 1'b0;
    end else if (strobes.idleReset) begin
      lineCount <= '0;
      inFrame   <= 1'b0;
    end else if (tickEff) begin
      lineCount <= nextCount;
      inFrame   <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            pending <= 1'b0;
    else if (hit)         pending <= 1'b1;
    else if (strobes.ack) pending <= 1'b0;
  end

  assign irqN = ~pending;

  p_count_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    tickEff |=> (lineCount == $past(lineCount) + 1'b1) && inFrame);
  p_match_irq_r4: assert property (@(posedge clk) disable iff (!rstN)
    hit |=> !irqN);
  p_ack_release_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.ack && !strobes.tick) |=> irqN);
  p_idle_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.idleReset |=> (lineCount == '0) && !inFrame);
endmodule

// File: rtl/scanline_irq_snoop.sv
module scanline_irq_snoop
  import scanline_snoop_pkg::*;
#(
  parameter int ADDR_W      = 14,
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter bit EXACT_MATCH = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              videoRdN,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic              cpuM2,
  input  logic              tgtWr,
  input  logic [CNT_W-1:0]  tgtData,
  input  logic              statusRd,
  output logic [1:0]        statusData,
  output logic              irqN
);
  snoopStrobes_t strobes;
  logic pending, inFrame;

  snoop_ctrl #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES), .EXACT_MATCH(EXACT_MATCH)) ctrl_i (
    .clk(clk), .rstN(rstN), .videoRdN(videoRdN), .cpuM2(cpuM2),
    .fetchAddr(fetchAddr), .statusRd(statusRd), .strobes(strobes)
  );

  snoop_dp #(.CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .tgtWr(tgtWr), .tgtData(tgtData),
    .pending(pending), .inFrame(inFrame), .irqN(irqN)
  );

  assign statusData = {pending, inFrame};
endmodule

// File: tb/scanline_irq_snoop_tb_top.sv
module scanline_irq_snoop_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic videoRdN = 1'b1;
  logic cpuM2 = 1'b0;
  logic [13:0] fetchAddr = '0;
  logic tgtWr = 1'b0;
  logic [7:0] tgtData = '0;
  logic statusRd = 1'b0;
  logic [1:0] statusData, statusDataX;
  logic irqN, irqNX;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  scanline_irq_snoop #(.EXACT_MATCH(1'b0)) dut_i (
    .clk(clk), .rstN(rstN), .videoRdN(videoRdN), .fetchAddr(fetchAddr), .cpuM2(cpuM2),
    .tgtWr(tgtWr), .tgtData(tgtData), .statusRd(statusRd), .statusData(statusData), .irqN(irqN)
  );
  scanline_irq_snoop #(.EXACT_MATCH(1'b1)) dut_exact_i (
    .clk(clk), .rstN(rstN), .videoRdN(videoRdN), .fetchAddr(fetchAddr), .cpuM2(cpuM2),
    .tgtWr(tgtWr), .tgtData(tgtData), .statusRd(statusRd), .statusData(statusDataX), .irqN(irqNX)
  );

  task automatic waitClk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic fetch(input logic [13:0] a);
    fetchAddr = a; videoRdN = 1'b0; waitClk(4);
    videoRdN = 1'b1; waitClk(4);
  endtask

  task automatic m2Cycle();
    cpuM2 = 1'b1; waitClk(4);
    cpuM2 = 1'b0; waitClk(4);
  endtask

  // One modelled line: nametable reads split by pattern reads, then the dummy pair
  task automatic emitLine(input int idx);
    for (int t = 0; t < 4; t++) begin
      fetch(14'h2000 + 14'(idx * 32 + t));
      fetch(14'h0100 + 14'(t * 16));
      fetch(14'h0108 + 14'(t * 16));
    end
    fetch(14'h2200 + 14'(idx));
    fetch(14'h2200 + 14'(idx));
    m2Cycle();
  endtask

  task automatic idleFrame();
    m2Cycle(); m2Cycle(); m2Cycle();
  endtask

  task automatic readStatus(output logic [1:0] s, output logic [1:0] sx);
    statusRd = 1'b1;
    @(negedge clk);
    s = statusData; sx = statusDataX;
    @(posedge clk); #1;
    statusRd = 1'b0;
    waitClk(1);
  endtask

  task automatic writeTarget(input logic [7:0] v);
    tgtData = v; tgtWr = 1'b1; waitClk(1); tgtWr = 1'b0;
  endtask

  initial begin
    #1_800_000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [1:0] s, sx;
    waitClk(3);
    rstN = 1'b1;
    waitClk(2);
    chk("R10 irqN", irqN, 1);
    chk("R10 status", statusData, 0);
    chk("R10 status exact", statusDataX, 0);

    // Sweep of targets across a frame, both compare modes (R3, R4, R5)
    for (int tgt = 1; tgt <= 6; tgt++) begin
      idleFrame();
      readStatus(s, sx);
      writeTarget(8'(tgt));
      for (int l = 0; l < 8; l++) begin
        emitLine(l);
        chk($sformatf("R4 region tgt=%0d line=%0d", tgt, l), irqN, (l + 1 >= tgt) ? 0 : 1);
        chk($sformatf("R9 exact tgt=%0d line=%0d", tgt, l), irqNX, (l + 1 >= tgt) ? 0 : 1);
      end
      readStatus(s, sx);
      chk("R5 status pending+inFrame", s, 3);
      chk("R3 exact status", sx, 3);
      chk("R5 irq released", irqN, 1);
    end

    // R7: two quiet periods clear in-frame and counter
    idleFrame();
    readStatus(s, sx);
    chk("R7 inFrame cleared", s, 0);
    writeTarget(8'd2);
    emitLine(0);
    readStatus(s, sx);
    chk("R3 inFrame after tick", s, 1);
    m2Cycle(); m2Cycle();
    emitLine(1);
    chk("R7 count restarted", irqN, 1);
    emitLine(2);
    chk("R7 second line hits", irqN, 0);
    readStatus(s, sx);

    // R8: single quiet period keeps the count
    idleFrame();
    writeTarget(8'd2);
    emitLine(0);
    m2Cycle();
    emitLine(1);
    chk("R8 single quiet ignored", irqN, 0);
    readStatus(s, sx);

    // R6: target write keeps count
    idleFrame();
    writeTarget(8'd9);
    emitLine(0); emitLine(1); emitLine(2);
    writeTarget(8'd5);
    emitLine(3);
    chk("R6 not yet", irqN, 1);
    emitLine(4);
    chk("R6 count kept", irqN, 0);
    readStatus(s, sx);

    // R2: third consecutive nametable read does not tick, fourth does
    idleFrame();
    writeTarget(8'd2);
    fetch(14'h2001); fetch(14'h2002); fetch(14'h2003);
    chk("R2 third read no tick", irqN, 1);
    fetch(14'h2004);
    chk("R2 fourth read ticks", irqN, 0);
    chk("R9 differing addresses no tick", irqNX, 1);
    readStatus(s, sx);

    // R2: an intervening pattern read clears the flag
    idleFrame();
    writeTarget(8'd1);
    fetch(14'h2001); fetch(14'h0040); fetch(14'h2002);
    chk("R2 split pair no tick", irqN, 1);
    fetch(14'h2003);
    chk("R2 pair after split ticks", irqN, 0);
    readStatus(s, sx);

    // R1 / R9: 0x3000 is outside the window; exact mode ticks on equal address
    idleFrame();
    readStatus(s, sx);
    writeTarget(8'd1);
    fetch(14'h3000); fetch(14'h3000);
    chk("R1 0x3000 pair no tick", irqN, 1);
    chk("R9 equal addresses tick", irqNX, 0);
    readStatus(s, sx);

    // R7: idle reset also clears the pair flag
    idleFrame();
    writeTarget(8'd1);
    fetch(14'h2005);
    idleFrame();
    fetch(14'h2006);
    chk("R7 pair flag cleared", irqN, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule